// File: doc/BRIEF.md
# Host Boot Data Receive FIFO

This block sits on the slave side of a host data port. An external host loads boot data into the device one block at a time. For each block, the host first waits until configuration is allowed. It then writes a destination address and a transfer count, waits for the ready flag, and streams the block's data. The data comes as 8-bit or 16-bit host writes, chosen by a mode input. The block packs these writes into 32-bit words with the lowest byte lane filled first. The words go into a sixteen-word FIFO, which an internal consumer drains through a valid/ready port.

Flow control works in two ways. The host can poll a three-bit status word. It can also watch the wait output and, in 8-bit mode, the acknowledge output. The acknowledge output pulses each time the host is granted a fresh FIFO's worth of words. The block counts the drained words. Once the whole block has been consumed, it drops the ready flag and allows configuration again. A control write can raise a one-cycle request that tells the internal side to run the loaded code.

Host register select `host_sel`: 0 = data, 1 = destination address, 2 = transfer count (in host beats), 3 = control.

Top module: `hostboot_rxfifo`

## Requirements
- R1: While reset is held, status is 3'b000, `host_wait` is 1 and `drain_valid` is 0. At the first clock edge after reset is released, the allow flag (status bit 0) sets and `host_wait` falls.
- R2: Writes to the destination (sel 1) and count (sel 2) registers take effect only while the allow flag is set. A nonzero count write clears the allow flag and sets the ready flag (status bit 1), both visible in the next cycle. A count of zero is ignored.
- R3: In 16-bit mode (`mode8`=0), the first beat of a word fills bits 15:0 and the second beat fills bits 31:16.
- R4: In 8-bit mode (`mode8`=1), only `host_wdata[7:0]` is used. Successive beats fill bits 7:0, 15:8, 23:16 and 31:24 in that order.
- R5: When the last counted beat ends partway through a word, that word is pushed with its unfilled upper lanes set to zero.
- R6: The FIFO holds 16 words. A data write that arrives while ready is set and the FIFO is full is dropped and does not count toward the block. It also sets the overflow flag (status bit 2), which stays set until reset.
- R7: Data writes while the ready flag is clear are ignored and push nothing.
- R8: Once ceil(beats / beats-per-word) words have been drained, the ready flag clears and the allow flag sets, both in the cycle after the last pop.
- R9: `host_wait` is high whenever the allow flag is clear and either the ready flag is clear or the FIFO is full.
- R10: In 8-bit mode, `host_ack` pulses for one cycle in two cases: in the cycle after an accepted count write, and in the cycle after a pop empties the FIFO while host beats are still owed. It never pulses in 16-bit mode.
- R11: A control write with bit 0 set while the allow flag is set produces a one-cycle `exec_req` pulse in the next cycle. A control write at any other time has no effect.
- R12: `drain_data` shows the oldest word. It is held stable while `drain_valid` is high and `drain_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode8 | input | 1 | 1 = 8-bit host beats, 0 = 16-bit; held constant during a block |
| host_wr | input | 1 | Host write strobe, one write per cycle |
| host_sel | input | 2 | Host register select |
| host_wdata | input | 16 | Host write data |
| host_status | output | 3 | {overflow, ready, allow} |
| blk_dest | output | 16 | Destination address of the current block |
| host_wait | output | 1 | Host must hold off |
| host_ack | output | 1 | Burst grant pulse (8-bit mode) |
| exec_req | output | 1 | Request to run loaded code |
| drain_valid | output | 1 | FIFO holds a word |
| drain_ready | input | 1 | Consumer takes the word this cycle |
| drain_data | output | 32 | Oldest FIFO word |

## Verification
The assertions check several rules on every cycle. The allow and ready flags are never both set. Ready rises only after an accepted count write. The FIFO occupancy never exceeds its depth, and no push happens while it is full. Overflow stays set once it is set. The acknowledge pulse occurs only in 8-bit mode. An execute request follows only an allowed control write. Drained data holds steady under back-pressure.

Some behaviour can only be shown by the bench's scenarios. These are the lane order of packed bytes and halfwords, the zero padding of short final words, the exclusion of a dropped beat from the block, and the exact cycle in which a fully drained block returns the port to configuration.

// File: rtl/hostboot_pkg.sv
package hostboot_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DEST = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_CTL  = 2'd3
  } host_sel_e;

  // words produced by a block of host beats, rounded up
  function automatic logic [15:0] hb_words(input logic [15:0] beats, input logic m8);
    logic [16:0] ext;
    ext = m8 ? ({1'b0, beats} + 17'd3) >> 2 : ({1'b0, beats} + 17'd1) >> 1;
    return ext[15:0];
  endfunction

  // byte offset of the lane after the current one
  function automatic logic [1:0] hb_next_off(input logic [1:0] off, input logic m8);
    return m8 ? off + 2'd1 : off + 2'd2;
  endfunction
endpackage

// File: rtl/hb_packer.sv
module hb_packer
  import hostboot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              beat_vld,
  input  logic              m8,
  input  logic              last,
  input  logic [15:0]       wdata,
  output logic              push,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] acc_q;
  logic [1:0]        off_q;
  logic [WORD_W-1:0] ins;
  logic [4:0]        sh;
  logic              word_end;

  always_comb begin
    sh       = {off_q, 3'b000};
    ins      = m8 ? ({24'b0, wdata[7:0]} << sh) : ({16'b0, wdata} << sh);
    word     = acc_q | ins;
    word_end = m8 ? (off_q == 2'd3) : (off_q == 2'd2);
    push     = beat_vld & (word_end | last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q <= '0;
      off_q <= '0;
    end else if (beat_vld) begin
      if (push) begin
        acc_q <= '0;
        off_q <= '0;
      end else begin
        acc_q <= word;
        off_q <= hb_next_off(off_q, m8);
      end
    end
  end
endmodule

// File: rtl/hb_fifo.sv
module hb_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic [AW:0]  cnt
);
  localparam logic [AW:0] FULLC = (AW+1)'(DEPTH);
  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;

  assign dout = mem[rp_q];

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
      cnt  <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  assert_push_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < FULLC || pop));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULLC);
endmodule

// File: rtl/hostboot_rxfifo.sv
module hostboot_rxfifo
  import hostboot_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode8,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [15:0]       host_wdata,
  output logic [2:0]        host_status,
  output logic [15:0]       blk_dest,
  output logic              host_wait,
  output logic              host_ack,
  output logic              exec_req,
  output logic              drain_valid,
  input  logic              drain_ready,
  output logic [WORD_W-1:0] drain_data
);
  localparam logic [AW:0] FULLC = (AW+1)'(DEPTH);

  logic        boot_q, allow_q, ready_q, ovf_q, ack_q, exec_q;
  logic [15:0] beats_left_q, words_left_q, dest_q;
  logic [AW:0] fcnt;

  // named internal events
  logic wr_data, wr_dest, wr_cnt, wr_ctl;
  logic cnt_ok, fifo_full, beat_ok, beat_drop, pop, blk_done, pk_push, empty_evt;
  logic [WORD_W-1:0] pk_word;

  always_comb begin
    wr_data   = host_wr && host_sel == SEL_DATA;
    wr_dest   = host_wr && host_sel == SEL_DEST;
    wr_cnt    = host_wr && host_sel == SEL_CNT;
    wr_ctl    = host_wr && host_sel == SEL_CTL;
    cnt_ok    = wr_cnt && allow_q && host_wdata != 16'd0;
    fifo_full = fcnt == FULLC;
    beat_ok   = wr_data && ready_q && beats_left_q != 16'd0 && !fifo_full;
    beat_drop = wr_data && ready_q && beats_left_q != 16'd0 && fifo_full;
    pop       = drain_valid && drain_ready;
    blk_done  = pop && words_left_q == 16'd1;
    empty_evt = pop && fcnt == (AW+1)'(1) && !pk_push && beats_left_q != 16'd0;
  end

  hb_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clr(cnt_ok), .beat_vld(beat_ok), .m8(mode8),
    .last(beats_left_q == 16'd1), .wdata(host_wdata), .push(pk_push), .word(pk_word)
  );

  hb_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(pk_push), .din(pk_word),
    .pop(pop), .dout(drain_data), .cnt(fcnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q <= 1'b0; allow_q <= 1'b0; ready_q <= 1'b0; ovf_q <= 1'b0;
      ack_q <= 1'b0; exec_q <= 1'b0; dest_q <= '0;
      beats_left_q <= '0; words_left_q <= '0;
    end else begin
      if (!boot_q) begin
        boot_q  <= 1'b1;
        allow_q <= 1'b1;
      end
      if (wr_dest && allow_q) dest_q <= host_wdata;
      if (cnt_ok) begin
        allow_q      <= 1'b0;
        ready_q      <= 1'b1;
        beats_left_q <= host_wdata;
        words_left_q <= hb_words(host_wdata, mode8);
      end
      if (beat_ok) beats_left_q <= beats_left_q - 16'd1;
      if (beat_drop) ovf_q <= 1'b1;
      if (pop) words_left_q <= words_left_q - 16'd1;
      if (blk_done) begin
        ready_q <= 1'b0;
        allow_q <= 1'b1;
      end
      exec_q <= wr_ctl && allow_q && host_wdata[0];
      ack_q  <= mode8 && (cnt_ok || empty_evt);
    end
  end

  assign host_status = {ovf_q, ready_q, allow_q};
  assign blk_dest    = dest_q;
  assign host_wait   = !allow_q && (!ready_q || fifo_full);
  assign host_ack    = ack_q;
  assign exec_req    = exec_q;
  assign drain_valid = fcnt != '0;

  assert_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(allow_q && ready_q));
  assert_ready_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(cnt_ok));
  assert_done_allow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_q) |-> allow_q);
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  assert_ack_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> $past(mode8));
  assert_exec_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req |-> $past(allow_q) && $past(wr_ctl));
  assert_drain_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid && !drain_ready |=> drain_valid && $stable(drain_data));
endmodule

// File: tb/sim_hostboot_rxfifo.sv
module sim_hostboot_rxfifo;
  localparam int TCLK = 10;
  // {mode8, beats[7:0], seed[15:0]}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 8'd4, 16'h1100}, {1'b0, 8'd3, 16'hA0B1}, {1'b1, 8'd8, 16'h0010},
    {1'b1, 8'd5, 16'h00C3}, {1'b1, 8'd2, 16'h7E00}, {1'b0, 8'd1, 16'hFFFE}};

  logic clk = 0, rst_n = 0, mode8 = 0, host_wr = 0, drain_ready = 0;
  logic [1:0] host_sel = 0;
  logic [15:0] host_wdata = 0, blk_dest;
  logic [2:0] host_status;
  logic host_wait, host_ack, exec_req, drain_valid;
  logic [31:0] drain_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(TCLK/2) clk = ~clk;

  hostboot_rxfifo u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    host_wr = 1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic drain(input logic [31:0] exp, input string req);
    chk(drain_valid === 1'b1 && drain_data === exp, req, drain_data, exp);
    drain_ready = 1;
    @(negedge clk);
    drain_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual %h expected %h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b [64];
    repeat (3) @(negedge clk);
    chk(host_status == 3'b000 && host_wait && !drain_valid, "R1 reset", {host_status, host_wait}, 4'b0001);
    rst_n = 1;
    @(negedge clk);
    chk(host_status == 3'b001 && !host_wait, "R1 allow after reset", {host_status, host_wait}, 4'b0010);

    // R7: data while not ready
    wr(2'd0, 16'hBAD0);
    chk(!drain_valid, "R7 data ignored when not ready", drain_valid, 0);
    // R2: zero count ignored
    wr(2'd2, 16'd0);
    chk(host_status == 3'b001, "R2 zero count ignored", host_status, 3'b001);
    // R11: exec while allowed
    wr(2'd3, 16'h0001);
    chk(exec_req, "R11 exec pulse", exec_req, 1);
    @(negedge clk);
    chk(!exec_req, "R11 exec one cycle", exec_req, 0);

    // vector table
    foreach (VEC[v]) begin
      int n, nw;
      logic m8;
      logic [15:0] d;
      m8 = VEC[v][24];
      n = 0;
      for (int i = 0; i < 64; i++) b[i] = 8'h00;
      for (int i = 0; i < int'(VEC[v][23:16]); i++) begin
        d = VEC[v][15:0] + 16'(i * 16'h0101);
        b[n] = d[7:0]; n++;
        if (!m8) begin b[n] = d[15:8]; n++; end
      end
      nw = (n + 3) / 4;
      mode8 = m8;
      wr(2'd1, 16'h4000 + 16'(v));
      chk(blk_dest == 16'h4000 + 16'(v), "R2 dest write", blk_dest, 16'h4000 + 16'(v));
      wr(2'd2, {8'd0, VEC[v][23:16]});
      chk(host_status == 3'b010, "R2 ready after count", host_status, 3'b010);
      chk(host_ack == m8, "R10 ack on grant", host_ack, m8);
      for (int i = 0; i < int'(VEC[v][23:16]); i++)
        wr(2'd0, VEC[v][15:0] + 16'(i * 16'h0101));
      chk(!host_ack, "R10 ack one cycle", host_ack, 0);
      for (int w = 0; w < nw; w++)
        drain({b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]}, m8 ? "R4 R5 byte pack" : "R3 R5 half pack");
      chk(host_status == 3'b001 && !drain_valid, "R8 block done", host_status, 3'b001);
    end

    // overflow in 16-bit mode
    mode8 = 0;
    wr(2'd1, 16'h0777);
    wr(2'd2, 16'd40);
    wr(2'd1, 16'h5555);
    chk(blk_dest == 16'h0777, "R2 dest locked while ready", blk_dest, 16'h0777);
    wr(2'd3, 16'h0001);
    chk(!exec_req, "R11 exec ignored while ready", exec_req, 0);
    chk(!host_wait, "R9 no wait while room", host_wait, 0);
    for (int i = 0; i < 32; i++) wr(2'd0, 16'h1000 + 16'(i));
    chk(host_wait, "R9 wait when full", host_wait, 1);
    chk(host_status[2] == 0, "R6 no overflow yet", host_status, 3'b010);
    wr(2'd0, 16'hDEAD);
    chk(host_status == 3'b110, "R6 overflow set", host_status, 3'b110);
    drain_ready = 0;
    @(negedge clk);
    chk(drain_data == 32'h10011000, "R12 held under backpressure", drain_data, 32'h10011000);
    for (int k = 0; k < 16; k++)
      drain({16'h1000 + 16'(2*k+1), 16'h1000 + 16'(2*k)}, "R6 fifo contents");
    chk(!host_ack, "R10 no ack in 16-bit", host_ack, 0);
    for (int i = 0; i < 8; i++) wr(2'd0, 16'h2000 + 16'(i));
    for (int k = 0; k < 4; k++)
      drain({16'h2000 + 16'(2*k+1), 16'h2000 + 16'(2*k)}, "R6 dropped beat not counted");
    chk(host_status == 3'b101, "R8 R6 done with sticky overflow", host_status, 3'b101);

    // 8-bit burst grant
    mode8 = 1;
    wr(2'd2, 16'd68);
    chk(host_ack, "R10 first grant", host_ack, 1);
    for (int i = 0; i < 64; i++) wr(2'd0, 16'(i));
    for (int k = 0; k < 16; k++)
      drain({8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)}, "R4 burst data");
    chk(host_ack, "R10 regrant on empty", host_ack, 1);
    @(negedge clk);
    chk(!host_ack, "R10 regrant one cycle", host_ack, 0);
    for (int i = 0; i < 4; i++) wr(2'd0, 16'h00F0 + 16'(i));
    drain(32'hF3F2F1F0, "R4 tail word");
    chk(host_status == 3'b101 && !host_ack, "R8 R10 final drain", {host_status, host_ack}, 4'b1010);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule